// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Status Word

This block is the arithmetic and logic datapath of a small microcontroller core, together with the status word register that holds its flags. An operation code selects one of eight byte operations: add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. A mode input switches to 16-bit words. In that mode only add, subtract and compare are legal. The result is combinational from the operands. The zero, auxiliary-carry and carry flags are written into the status word at the next clock edge.

The status word also holds the interrupt-enable bit, the interrupt-priority bit and the two register-bank-select bits. Software can load the whole word in one cycle. The bank-select bits and the interrupt bits are brought out as separate outputs, which the rest of the core uses for register-bank addressing and interrupt control. A separate step input increments or decrements the low byte of the destination operand. A step updates zero and auxiliary carry and leaves carry unchanged.

Top module: `alu_psw`

## Requirements
- R1: With `op_valid` high and `wide` low, `result` is {8'h00, dst op src} on the low bytes. The codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 AND, 5 XOR, 6 OR, 7 compare. When neither `op_valid` nor `step_valid` is high, `result` is 0.
- R2: An arithmetic code (0, 1, 2, 3, 7) writes Z, AC and CY into the status word at the next rising edge. Z is 1 exactly when the arithmetic result is zero.
- R3: AND, XOR and OR write only Z at the next edge. AC and CY keep their values.
- R4: Compare drives `result` equal to the destination operand. It sets the flags exactly as subtract of the same operands would.
- R5: With `wide` high, only codes 0, 2 and 7 act on all 16 bits. Any other code raises `op_invalid` in the same cycle and leaves the status word unchanged.
- R6: AC is the carry or borrow out of bit 3 in byte mode and out of bit 11 in word mode.
- R7: CY is the carry out of the top bit for add. For subtract and compare it is the borrow, set when src plus the incoming borrow exceeds dst as unsigned numbers. Codes 1 and 3 use the current CY as carry-in or borrow-in. The other codes use 0.
- R8: `step_valid` with `op_valid` low gives `result` = {8'h00, dst[7:0] + 1}, or dst[7:0] - 1 when `step_down` is high. At the next edge it writes Z and AC and keeps CY. When both strobes are high, the operation wins.
- R9: Status word bit positions: 7 interrupt enable, 6 Z, 5 bank-select high, 4 AC, 3 bank-select low, 2 unused (always reads 0), 1 interrupt priority, 0 CY. `psw_wr` loads all defined bits at the next edge.
- R10: `psw_wr` takes precedence over any flag update in the same cycle.
- R11: `bank_sel` is {bit 5, bit 3} of the status word. `int_en` is bit 7 and `int_prio` is bit 1.
- R12: While `rst_n` is low, the status word is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| op_valid | input | 1 | Perform the operation selected by `op_code` |
| op_code | input | 3 | Operation select |
| wide | input | 1 | 1 = 16-bit operands, 0 = 8-bit |
| dst_in | input | 16 | Destination operand |
| src_in | input | 16 | Source operand |
| step_valid | input | 1 | Increment or decrement the destination byte |
| step_down | input | 1 | 1 = decrement, 0 = increment |
| psw_wr | input | 1 | Load the whole status word |
| psw_wdata | input | 8 | Value for the status word load |
| result | output | 16 | Combinational result |
| op_invalid | output | 1 | Code is illegal in word mode |
| psw_q | output | 8 | Status word |
| bank_sel | output | 2 | Register-bank select |
| int_en | output | 1 | Interrupt enable bit |
| int_prio | output | 1 | Interrupt priority bit |

## Verification
Each byte operation is tried with operands that carry out of the low nibble and operands that do not. Sums that wrap to zero separate the Z, AC and CY sources from each other. Subtract-with-borrow and add-with-carry are run with CY preset, so the carry-in path is exercised. Logic operations run with AC and CY preset to 1, which shows they are retained. Compare is run with equal operands and with a source one above the destination. Word-mode vectors place the auxiliary carry at bit 11 and try every illegal code. Step runs cross nibble and zero boundaries, and preset status words carry the bank and interrupt bits through every update.

// File: rtl/alu_psw_pkg.sv
package alu_psw_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_ADDC = 3'd1,
    OP_SUB  = 3'd2,
    OP_SUBB = 3'd3,
    OP_AND  = 3'd4,
    OP_XOR  = 3'd5,
    OP_OR   = 3'd6,
    OP_CMP  = 3'd7
  } alu_op_e;

  // Field order is the bit order of the status word, msb first.
  typedef struct packed {
    logic ie;
    logic zf;
    logic bank_hi;
    logic acf;
    logic bank_lo;
    logic spare;
    logic prio;
    logic cyf;
  } psw_t;

  localparam logic [7:0] PSW_DEFINED_MASK = 8'hFB;

  function automatic logic op_is_arith(alu_op_e op);
    return !(op inside {OP_AND, OP_XOR, OP_OR});
  endfunction

  function automatic logic op_subtracts(alu_op_e op);
    return op inside {OP_SUB, OP_SUBB, OP_CMP};
  endfunction

  function automatic logic op_uses_cin(alu_op_e op);
    return op inside {OP_ADDC, OP_SUBB};
  endfunction

  function automatic logic op_legal_wide(alu_op_e op);
    return op inside {OP_ADD, OP_SUB, OP_CMP};
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W = 8,
  localparam int ACW = W - 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         half
);

  logic [W:0]   full;
  logic [ACW:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - (W+1)'(cin);
      low  = {1'b0, a[ACW-1:0]} - {1'b0, b[ACW-1:0]} - (ACW+1)'(cin);
    end else begin
      full = {1'b0, a} + {1'b0, b} + (W+1)'(cin);
      low  = {1'b0, a[ACW-1:0]} + {1'b0, b[ACW-1:0]} + (ACW+1)'(cin);
    end
  end

  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign half = low[ACW];

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_psw_pkg::*;
#(
  parameter int W       = 8,
  parameter bit LIMITED = 1'b0
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         zf,
  output logic         acf,
  output logic         cyf,
  output logic         legal
);

  logic [W-1:0] ar_sum;
  logic         ar_cout;
  logic         ar_half;

  alu_arith #(.W(W)) u_arith (
    .a    (a),
    .b    (b),
    .cin  (cin & op_uses_cin(op)),
    .sub  (op_subtracts(op)),
    .sum  (ar_sum),
    .cout (ar_cout),
    .half (ar_half)
  );

  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_XOR:  res = a ^ b;
      OP_OR:   res = a | b;
      OP_CMP:  res = a;
      default: res = ar_sum;
    endcase
  end

  assign zf  = (op == OP_CMP) ? (ar_sum == '0) : (res == '0);
  assign acf = ar_half;
  assign cyf = ar_cout;

  generate
    if (LIMITED) begin : g_limited
      assign legal = op_legal_wide(op);
    end else begin : g_full
      assign legal = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/alu_psw_reg.sv
module alu_psw_reg
  import alu_psw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_all,
  input  logic [7:0] load_val,
  input  logic       set_z,
  input  logic       z_val,
  input  logic       set_ac,
  input  logic       ac_val,
  input  logic       set_cy,
  input  logic       cy_val,
  output psw_t       psw
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw <= '0;
    end else if (load_all) begin
      psw <= psw_t'(load_val & PSW_DEFINED_MASK);
    end else begin
      if (set_z)  psw.zf  <= z_val;
      if (set_ac) psw.acf <= ac_val;
      if (set_cy) psw.cyf <= cy_val;
    end
  end

  p_spare_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    psw.spare == 1'b0);

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_all && !set_z && !set_ac && !set_cy) |=> $stable(psw));

endmodule

// File: rtl/alu_psw.sv
module alu_psw
  import alu_psw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic        wide,
  input  logic [15:0] dst_in,
  input  logic [15:0] src_in,
  input  logic        step_valid,
  input  logic        step_down,
  input  logic        psw_wr,
  input  logic [7:0]  psw_wdata,
  output logic [15:0] result,
  output logic        op_invalid,
  output logic [7:0]  psw_q,
  output logic [1:0]  bank_sel,
  output logic        int_en,
  output logic        int_prio
);

  alu_op_e op;
  psw_t    psw_cur;

  logic [7:0]  res_n;
  logic        z_n, ac_n, cy_n, legal_n;
  logic [15:0] res_w;
  logic        z_w, ac_w, cy_w, legal_w;
  logic [7:0]  res_s;
  logic        ac_s, cy_s_unused;

  // Named internal events
  logic go_n, go_w, go_s, arith;
  logic set_z, set_ac, set_cy;
  logic z_val, ac_val, cy_val;

  assign op = alu_op_e'(op_code);

  alu_unit #(.W(8), .LIMITED(1'b0)) u_narrow (
    .op    (op),
    .a     (dst_in[7:0]),
    .b     (src_in[7:0]),
    .cin   (psw_cur.cyf),
    .res   (res_n),
    .zf    (z_n),
    .acf   (ac_n),
    .cyf   (cy_n),
    .legal (legal_n)
  );

  alu_unit #(.W(16), .LIMITED(1'b1)) u_wide (
    .op    (op),
    .a     (dst_in),
    .b     (src_in),
    .cin   (psw_cur.cyf),
    .res   (res_w),
    .zf    (z_w),
    .acf   (ac_w),
    .cyf   (cy_w),
    .legal (legal_w)
  );

  alu_arith #(.W(8)) u_step (
    .a    (dst_in[7:0]),
    .b    (8'h01),
    .cin  (1'b0),
    .sub  (step_down),
    .sum  (res_s),
    .cout (cy_s_unused),
    .half (ac_s)
  );

  assign op_invalid = op_valid & (wide ? ~legal_w : ~legal_n);

  assign go_n  = op_valid & ~wide;
  assign go_w  = op_valid & wide & legal_w;
  assign go_s  = step_valid & ~op_valid;
  assign arith = op_is_arith(op);

  assign set_z  = go_n | go_w | go_s;
  assign set_ac = (go_n & arith) | go_w | go_s;
  assign set_cy = (go_n & arith) | go_w;

  always_comb begin
    if (go_w) begin
      z_val = z_w;  ac_val = ac_w;  cy_val = cy_w;
    end else if (go_n) begin
      z_val = z_n;  ac_val = ac_n;  cy_val = cy_n;
    end else begin
      z_val = (res_s == 8'h00);  ac_val = ac_s;  cy_val = 1'b0;
    end
  end

  always_comb begin
    if (op_valid && wide)  result = res_w;
    else if (op_valid)     result = {8'h00, res_n};
    else if (step_valid)   result = {8'h00, res_s};
    else                   result = 16'h0000;
  end

  alu_psw_reg u_psw (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_all (psw_wr),
    .load_val (psw_wdata),
    .set_z    (set_z),
    .z_val    (z_val),
    .set_ac   (set_ac),
    .ac_val   (ac_val),
    .set_cy   (set_cy),
    .cy_val   (cy_val),
    .psw      (psw_cur)
  );

  assign psw_q    = psw_cur;
  assign bank_sel = {psw_cur.bank_hi, psw_cur.bank_lo};
  assign int_en   = psw_cur.ie;
  assign int_prio = psw_cur.prio;

  p_psw_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    psw_wr |=> psw_q == ($past(psw_wdata) & 8'hFB));

  p_logic_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wide && op_code inside {3'd4, 3'd5, 3'd6} && !psw_wr)
      |=> (psw_q[0] == $past(psw_q[0])) && (psw_q[4] == $past(psw_q[4])));

  p_cmp_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 3'd7)
      |-> result == (wide ? dst_in : {8'h00, dst_in[7:0]}));

  p_invalid_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_invalid && !psw_wr) |=> $stable(psw_q));

  p_half_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wide && op_code == 3'd0 && !psw_wr)
      |=> psw_q[4] == (({1'b0, $past(dst_in[3:0])} + {1'b0, $past(src_in[3:0])}) > 5'd15));

  p_borrow_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !wide && op_code == 3'd2 && !psw_wr)
      |=> psw_q[0] == ($past(src_in[7:0]) > $past(dst_in[7:0])));

  p_step_keeps_cy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && !op_valid && !psw_wr) |=> psw_q[0] == $past(psw_q[0]));

endmodule

// File: tb/sim_alu_psw.sv
module sim_alu_psw;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic        wide = 1'b0;
  logic [15:0] dst_in = '0;
  logic [15:0] src_in = '0;
  logic        step_valid = 1'b0;
  logic        step_down = 1'b0;
  logic        psw_wr = 1'b0;
  logic [7:0]  psw_wdata = '0;
  logic [15:0] result;
  logic        op_invalid;
  logic [7:0]  psw_q;
  logic [1:0]  bank_sel;
  logic        int_en;
  logic        int_prio;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu_psw u0 (.*);

  typedef struct packed {
    logic        wide;
    logic [2:0]  op;
    logic [7:0]  pre;
    logic [15:0] dst;
    logic [15:0] src;
    logic [15:0] res;
    logic [7:0]  post;
  } vec_t;

  // Flags: Z=0x40, AC=0x10, CY=0x01
  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 8'h00, 16'h000F, 16'h0001, 16'h0010, 8'h10}, // R1 R6 add nibble carry
    '{1'b0, 3'd0, 8'h00, 16'h00FF, 16'h0001, 16'h0000, 8'h51}, // R2 R7 wrap to zero
    '{1'b0, 3'd1, 8'h01, 16'h0010, 16'h0020, 16'h0031, 8'h00}, // R7 carry-in
    '{1'b0, 3'd2, 8'h00, 16'h0010, 16'h0001, 16'h000F, 8'h10}, // R6 borrow bit 3
    '{1'b0, 3'd3, 8'h01, 16'h0005, 16'h0005, 16'h00FF, 8'h11}, // R7 borrow-in
    '{1'b0, 3'd4, 8'h11, 16'h00F0, 16'h000F, 16'h0000, 8'h51}, // R3 and
    '{1'b0, 3'd5, 8'h51, 16'h00AA, 16'h0055, 16'h00FF, 8'h11}, // R3 xor
    '{1'b0, 3'd6, 8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h40}, // R3 or
    '{1'b0, 3'd6, 8'h11, 16'h0081, 16'h0018, 16'h0099, 8'h11}, // R3 or keeps
    '{1'b0, 3'd7, 8'h00, 16'h0030, 16'h0030, 16'h0030, 8'h40}, // R4 cmp equal
    '{1'b0, 3'd7, 8'h40, 16'h0020, 16'h0021, 16'h0020, 8'h11}, // R4 R7 cmp below
    '{1'b1, 3'd0, 8'h00, 16'h0FFF, 16'h0001, 16'h1000, 8'h10}, // R6 bit 11
    '{1'b1, 3'd0, 8'h00, 16'hFFFF, 16'h0001, 16'h0000, 8'h51}, // R5 word wrap
    '{1'b1, 3'd2, 8'h00, 16'h1000, 16'h0001, 16'h0FFF, 8'h10}, // R6 borrow bit 11
    '{1'b1, 3'd7, 8'h00, 16'h1234, 16'h1235, 16'h1234, 8'h11}, // R4 word cmp
    '{1'b1, 3'd2, 8'h01, 16'h8000, 16'h0001, 16'h7FFF, 8'h10}, // R7 word sub ignores cy
    '{1'b0, 3'd0, 8'hEA, 16'hAB01, 16'hCD02, 16'h0003, 8'hAA}  // R1 R9 high bytes, status kept
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load_psw(input logic [7:0] v);
    @(negedge clk);
    psw_wr = 1'b1; psw_wdata = v;
    @(negedge clk);
    psw_wr = 1'b0;
  endtask

  task automatic run_op(input logic w, input logic [2:0] oc, input logic [15:0] d, input logic [15:0] s);
    op_valid = 1'b1; wide = w; op_code = oc; dst_in = d; src_in = s;
    #1;
  endtask

  task automatic run_step(input logic dn, input logic [7:0] d);
    step_valid = 1'b1; step_down = dn; dst_in = {8'h00, d};
    #1;
  endtask

  task automatic idle_after_edge();
    @(negedge clk);
    op_valid = 1'b0; step_valid = 1'b0; wide = 1'b0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #12;
    check("R12 psw", {8'h00, psw_q}, 16'h0000);
    check("R12 bank", {14'h0, bank_sel}, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 idle result", result, 16'h0000);

    foreach (VEC[i]) begin
      load_psw(VEC[i].pre);
      run_op(VEC[i].wide, VEC[i].op, VEC[i].dst, VEC[i].src);
      check($sformatf("R1 vec %0d result", i), result, VEC[i].res);
      check($sformatf("R2 vec %0d invalid", i), {15'h0, op_invalid}, 16'h0000);
      idle_after_edge();
      check($sformatf("R2 vec %0d psw", i), {8'h00, psw_q}, {8'h00, VEC[i].post});
    end

    // R9 R11 whole-word load
    load_psw(8'hFF);
    check("R9 load all", {8'h00, psw_q}, 16'h00FB);
    check("R11 bank 3", {14'h0, bank_sel}, 16'h0003);
    check("R11 ie/prio", {14'h0, int_en, int_prio}, 16'h0003);
    load_psw(8'h20);
    check("R11 bank hi", {14'h0, bank_sel}, 16'h0002);
    check("R11 ie/prio clr", {14'h0, int_en, int_prio}, 16'h0000);
    load_psw(8'h08);
    check("R11 bank lo", {14'h0, bank_sel}, 16'h0001);

    // R5 illegal word codes
    for (int c = 1; c < 7; c++) begin
      if (c == 2) continue;
      load_psw(8'h51);
      run_op(1'b1, 3'(c), 16'h0F0F, 16'h00F1);
      check($sformatf("R5 code %0d flag", c), {15'h0, op_invalid}, 16'h0001);
      idle_after_edge();
      check($sformatf("R5 code %0d psw", c), {8'h00, psw_q}, 16'h0051);
    end

    // R8 step
    load_psw(8'h01);
    run_step(1'b0, 8'h0F);
    check("R8 inc result", result, 16'h0010);
    idle_after_edge();
    check("R8 inc psw", {8'h00, psw_q}, 16'h0011);
    load_psw(8'h00);
    run_step(1'b1, 8'h01);
    check("R8 dec result", result, 16'h0000);
    idle_after_edge();
    check("R8 dec zero psw", {8'h00, psw_q}, 16'h0040);
    load_psw(8'h01);
    run_step(1'b1, 8'h00);
    check("R8 dec wrap", result, 16'h00FF);
    idle_after_edge();
    check("R8 dec wrap psw", {8'h00, psw_q}, 16'h0011);
    load_psw(8'h00);
    run_step(1'b0, 8'hFF);
    check("R8 inc wrap", result, 16'h0000);
    idle_after_edge();
    check("R8 inc wrap psw", {8'h00, psw_q}, 16'h0050);

    // R8 operation wins over step
    load_psw(8'h00);
    step_valid = 1'b1; step_down = 1'b1;
    run_op(1'b0, 3'd0, 16'h0005, 16'h0003);
    check("R8 op priority", result, 16'h0008);
    idle_after_edge();
    check("R8 op priority psw", {8'h00, psw_q}, 16'h0000);

    // R10 load beats operation
    load_psw(8'h00);
    @(negedge clk);
    psw_wr = 1'b1; psw_wdata = 8'h82;
    run_op(1'b0, 3'd0, 16'h00FF, 16'h0001);
    @(negedge clk);
    psw_wr = 1'b0; op_valid = 1'b0;
    check("R10 load priority", {8'h00, psw_q}, 16'h0082);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule